// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block keeps one 32-bit control/status word for each of a parameterised number of DMA channels, normally 16 or 32. Software writes a channel's word through a port selected by channel index. The channel engines report events on per-channel strobes: start, end, stop, end-of-receive, request-after-stop and bus error. Each strobe sets a sticky flag in the word. Software clears most of these flags by writing ones to them.

The block turns each channel's flags into one summary bit. Some causes reach the summary only when the channel's matching enable bit is set, and others always reach it. One interrupt line is the OR of all summary bits. A channel's run, no-descriptor-fetch and compare state is driven out to its engine. A write that starts a channel in descriptor-fetch mode produces a one-cycle fetch request. The read port is combinational and folds the live peripheral-request input of the selected channel into the returned word.

Top module: `dma_status_agg`

## Requirements
- R1: After reset every channel reads 0x0000_0008, with only the stop flag (bit 3) set. The summary bits, the interrupt line, run_o, nofetch_o, cmp_o and fetch_go are all zero.
- R2: A write stores data bits 31:26 and bit 23 in the selected channel. Bit 22 (mask-run), bits 24 and 25 and the remaining unlisted bits are never stored and always read as 0.
- R3: A write clears flag bits 0, 1, 2 and 9 wherever the written data has a one, and leaves the other flags alone. An event that arrives in the same cycle as the clearing write takes priority, so the flag stays set.
- R4: An event strobe sets its flag at the next clock edge. The flags are bit 0 bus error, bit 1 start, bit 2 end, bit 3 stop and bit 9 end-of-receive. These flags hold until software clears them.
- R5: The request-after-stop flag (bit 4) is set by its event. It holds while the channel's req_active input is high and clears at the first edge where req_active is low and no new event arrives.
- R6: Read data bit 8 equals req_active of the channel being read, in the same cycle.
- R7: A write with bit 31 = 0 and bit 22 = 0 sets the stop flag. A write with bit 31 = 1 and bit 30 = 0 clears the stop flag and raises fetch_go for that channel for exactly one cycle after the write. Any other write leaves the stop flag unchanged.
- R8: Written bit 24 clears the compare flag (bit 10) and written bit 25 sets it. When both are written together, set wins.
- R9: A channel's summary bit is the OR of five terms: start, end, stop AND bit 29, end-of-receive AND bit 28, and request-after-stop AND bit 23. The bus error flag never contributes.
- R10: irq_o is high exactly when at least one summary bit is set.
- R11: run_o, nofetch_o and cmp_o of each channel show that channel's stored bits 31, 30 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel index of the write |
| wr_data | input | 32 | Write data |
| rd_ch | input | CHW | Channel index of the read |
| rd_data | output | 32 | Stored word of rd_ch, with bit 8 showing its live request |
| ev_buserr | input | NUM_CH | Bus error event, one per channel |
| ev_start | input | NUM_CH | Start event, one per channel |
| ev_end | input | NUM_CH | End event, one per channel |
| ev_stop | input | NUM_CH | Stop event, one per channel |
| ev_eor | input | NUM_CH | End-of-receive event, one per channel |
| ev_ras | input | NUM_CH | Request-after-stop event, one per channel |
| req_active | input | NUM_CH | Live peripheral request, one per channel |
| run_o | output | NUM_CH | Run bit of each channel |
| nofetch_o | output | NUM_CH | No-descriptor-fetch bit of each channel |
| cmp_o | output | NUM_CH | Compare flag of each channel |
| fetch_go | output | NUM_CH | One-cycle descriptor fetch request |
| irq_sum | output | NUM_CH | Per-channel interrupt summary |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench checks the priority between a clearing write and an event in the same cycle. A design that let the write win would lose an end flag and its interrupt. It checks the stop flag under three kinds of write: forced, cleared, and held by mask-run alone. A wrong decode would either stop a running channel or leave a stopped channel looking live. The bench also checks enable gating. It confirms that a bus error never raises the interrupt, while gated causes raise it only once their enable is written. It checks the compare set-and-clear tie, the request-after-stop flag dropping with its request, and the interrupt line following summary bits from opposite ends of the channel range.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

  localparam int unsigned CSR_W = 32;

  // flag positions
  localparam int unsigned B_BUSERR  = 0;
  localparam int unsigned B_START   = 1;
  localparam int unsigned B_END     = 2;
  localparam int unsigned B_STOP    = 3;
  localparam int unsigned B_RAS     = 4;
  localparam int unsigned B_REQ     = 8;
  localparam int unsigned B_EOR     = 9;
  localparam int unsigned B_CMP     = 10;
  // control positions
  localparam int unsigned B_MRUN    = 22;
  localparam int unsigned B_RASEN   = 23;
  localparam int unsigned B_CMPCLR  = 24;
  localparam int unsigned B_CMPSET  = 25;
  localparam int unsigned B_EORSTP  = 26;
  localparam int unsigned B_EORJMP  = 27;
  localparam int unsigned B_EOREN   = 28;
  localparam int unsigned B_STOPEN  = 29;
  localparam int unsigned B_NOFETCH = 30;
  localparam int unsigned B_RUN     = 31;

  // control bits that take the written value
  localparam logic [CSR_W-1:0] CTRL_STORE_MASK = 32'hFC80_0000;
  localparam logic [CSR_W-1:0] CSR_RST_VAL     = 32'h0000_0008;

  typedef struct packed {
    logic buserr;
    logic start;
    logic done;
    logic stop;
    logic eor;
    logic ras;
  } chan_evt_t;

endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CSR_W-1:0] wr_data,
  input  chan_evt_t        evt,
  input  logic             req_active,
  output logic [CSR_W-1:0] csr_q,
  output logic             fetch_go
);

  logic [CSR_W-1:0] csr_nxt;
  logic             csr_en;
  logic             start_fetch;
  logic             any_evt;

  assign any_evt     = evt.buserr | evt.start | evt.done | evt.stop | evt.eor | evt.ras;
  assign start_fetch = wr_hit & wr_data[B_RUN] & ~wr_data[B_NOFETCH];
  assign csr_en      = wr_hit | any_evt | (csr_q[B_RAS] & ~req_active);

  always_comb begin
    csr_nxt = csr_q;
    if (wr_hit) begin
      // write-one-to-clear flags
      csr_nxt[B_BUSERR] = csr_q[B_BUSERR] & ~wr_data[B_BUSERR];
      csr_nxt[B_START]  = csr_q[B_START]  & ~wr_data[B_START];
      csr_nxt[B_END]    = csr_q[B_END]    & ~wr_data[B_END];
      csr_nxt[B_EOR]    = csr_q[B_EOR]    & ~wr_data[B_EOR];
      // stored control field
      csr_nxt = (csr_nxt & ~CTRL_STORE_MASK) | (wr_data & CTRL_STORE_MASK);
      // stop flag handling
      if (start_fetch) begin
        csr_nxt[B_STOP] = 1'b0;
      end
      if (!wr_data[B_RUN] && !wr_data[B_MRUN]) begin
        csr_nxt[B_STOP] = 1'b1;
      end
      // compare one-shot commands, set after clear
      if (wr_data[B_CMPCLR]) begin
        csr_nxt[B_CMP] = 1'b0;
      end
      if (wr_data[B_CMPSET]) begin
        csr_nxt[B_CMP] = 1'b1;
      end
    end
    // engine events win over the write
    csr_nxt[B_BUSERR] = csr_nxt[B_BUSERR] | evt.buserr;
    csr_nxt[B_START]  = csr_nxt[B_START]  | evt.start;
    csr_nxt[B_END]    = csr_nxt[B_END]    | evt.done;
    csr_nxt[B_STOP]   = csr_nxt[B_STOP]   | evt.stop;
    csr_nxt[B_EOR]    = csr_nxt[B_EOR]    | evt.eor;
    csr_nxt[B_RAS]    = evt.ras | (csr_q[B_RAS] & req_active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= CSR_RST_VAL;
    end else if (csr_en) begin
      csr_q <= csr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_go <= 1'b0;
    end else begin
      fetch_go <= start_fetch;
    end
  end

endmodule

// File: rtl/dma_irq_contrib.sv
module dma_irq_contrib
  import dma_stat_pkg::*;
(
  input  logic [CSR_W-1:0] csr,
  output logic             contrib
);

  logic gated_stop;
  logic gated_eor;
  logic gated_ras;
  logic ungated;

  assign gated_stop = csr[B_STOP] & csr[B_STOPEN];
  assign gated_eor  = csr[B_EOR]  & csr[B_EOREN];
  assign gated_ras  = csr[B_RAS]  & csr[B_RASEN];
  assign ungated    = csr[B_START] | csr[B_END];
  assign contrib    = ungated | gated_stop | gated_eor | gated_ras;

endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CHW   = $clog2(NUM_CH)
)(
  input  logic [NUM_CH-1:0][CSR_W-1:0] csr,
  input  logic [NUM_CH-1:0]            req_active,
  input  logic [CHW-1:0]               rd_ch,
  output logic [CSR_W-1:0]             rd_data
);

  logic [CSR_W-1:0] sel_word;
  logic             sel_req;

  assign sel_word = csr[rd_ch];
  assign sel_req  = req_active[rd_ch];

  always_comb begin
    rd_data        = sel_word;
    rd_data[B_REQ] = sel_req;
  end

endmodule

// File: rtl/dma_status_agg.sv
module dma_status_agg
  import dma_stat_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CHW   = $clog2(NUM_CH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [31:0]       wr_data,
  input  logic [CHW-1:0]    rd_ch,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] ev_buserr,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_stop,
  input  logic [NUM_CH-1:0] ev_eor,
  input  logic [NUM_CH-1:0] ev_ras,
  input  logic [NUM_CH-1:0] req_active,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] nofetch_o,
  output logic [NUM_CH-1:0] cmp_o,
  output logic [NUM_CH-1:0] fetch_go,
  output logic [NUM_CH-1:0] irq_sum,
  output logic              irq_o
);

  logic [NUM_CH-1:0][CSR_W-1:0] csr_all;
  logic [NUM_CH-1:0]            wr_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_evt_t evt;

    assign wr_hit[c]  = wr_en && (wr_ch == CHW'(c));
    assign evt.buserr = ev_buserr[c];
    assign evt.start  = ev_start[c];
    assign evt.done   = ev_end[c];
    assign evt.stop   = ev_stop[c];
    assign evt.eor    = ev_eor[c];
    assign evt.ras    = ev_ras[c];

    dma_csr_chan u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_hit[c]),
      .wr_data    (wr_data),
      .evt        (evt),
      .req_active (req_active[c]),
      .csr_q      (csr_all[c]),
      .fetch_go   (fetch_go[c])
    );

    dma_irq_contrib u_irq (
      .csr     (csr_all[c]),
      .contrib (irq_sum[c])
    );

    assign run_o[c]     = csr_all[c][B_RUN];
    assign nofetch_o[c] = csr_all[c][B_NOFETCH];
    assign cmp_o[c]     = csr_all[c][B_CMP];
  end

  dma_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
    .csr        (csr_all),
    .req_active (req_active),
    .rd_ch      (rd_ch),
    .rd_data    (rd_data)
  );

  assign irq_o = |irq_sum;

endmodule

// File: rtl/dma_status_agg_chk.sv
module dma_status_agg_chk #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned CHW   = $clog2(NUM_CH)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CHW-1:0]    wr_ch,
  input logic [31:0]       wr_data,
  input logic [CHW-1:0]    rd_ch,
  input logic [31:0]       rd_data,
  input logic [NUM_CH-1:0] req_active,
  input logic [NUM_CH-1:0] run_o,
  input logic [NUM_CH-1:0] cmp_o,
  input logic [NUM_CH-1:0] fetch_go
);

  AST_RUN_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (run_o[$past(wr_ch)] == $past(wr_data[31]))); // R11

  AST_FETCH_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_go)); // R7

  AST_FETCH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go != '0) |-> ($past(wr_en) && $past(wr_data[31]) && !$past(wr_data[30]))); // R7

  AST_STOP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(wr_data[31]) && !$past(wr_data[22]) && (rd_ch == $past(wr_ch)))
      |-> rd_data[3]); // R7

  AST_CMP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25]) |=> cmp_o[$past(wr_ch)]); // R8

  AST_REQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[8] == req_active[rd_ch]); // R6

endmodule

bind dma_status_agg dma_status_agg_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_dma_status_agg.sv
`timescale 1ns/1ps
module sim_dma_status_agg;

  localparam int unsigned N   = 16;
  localparam int unsigned CHW = $clog2(N);

  logic           clk;
  logic           rst_n;
  logic           wr_en;
  logic [CHW-1:0] wr_ch;
  logic [31:0]    wr_data;
  logic [CHW-1:0] rd_ch;
  logic [31:0]    rd_data;
  logic [N-1:0]   ev_buserr, ev_start, ev_end, ev_stop, ev_eor, ev_ras;
  logic [N-1:0]   req_active;
  logic [N-1:0]   run_o, nofetch_o, cmp_o, fetch_go, irq_sum;
  logic           irq_o;

  int checks;
  int errors;

  dma_status_agg #(.NUM_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data),
    .ev_buserr(ev_buserr), .ev_start(ev_start), .ev_end(ev_end),
    .ev_stop(ev_stop), .ev_eor(ev_eor), .ev_ras(ev_ras),
    .req_active(req_active),
    .run_o(run_o), .nofetch_o(nofetch_o), .cmp_o(cmp_o),
    .fetch_go(fetch_go), .irq_sum(irq_sum), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input int ch, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_ch   = CHW'(ch);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic read_ch(input int ch, output logic [31:0] d);
    rd_ch = CHW'(ch);
    #1;
    d = rd_data;
  endtask

  task automatic idle();
    @(negedge clk);
    ev_buserr = '0; ev_start = '0; ev_end = '0;
    ev_stop = '0; ev_eor = '0; ev_ras = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < N; c++) begin
      read_ch(c, d);
      chk("R1 reset word", d, 32'h8);
    end
    chk("R1 reset summary", 32'(irq_sum), 32'h0);
    chk("R1 reset irq", 32'(irq_o), 32'h0);
    chk("R1 reset run/nofetch/cmp", 32'(run_o | nofetch_o | cmp_o | fetch_go), 32'h0);
  endtask

  task automatic t_control_store();
    logic [31:0] d;
    do_write(5, 32'hFCC0_0000);
    read_ch(5, d);
    chk("R2 stored control, bit22 dropped", d, 32'hFC80_0008);
    chk("R11 run_o", 32'(run_o[5]), 32'h1);
    chk("R11 nofetch_o", 32'(nofetch_o[5]), 32'h1);
    chk("R7 no fetch when nofetch set", 32'(fetch_go), 32'h0);
    chk("R9 stop gated in by enable", 32'(irq_sum), 32'h20);
    chk("R10 irq high", 32'(irq_o), 32'h1);
    do_write(5, 32'hDCC0_0000);
    read_ch(5, d);
    chk("R2 enable removed", d, 32'hDC80_0008);
    chk("R9 stop gated out", 32'(irq_sum), 32'h0);
    chk("R10 irq low", 32'(irq_o), 32'h0);
    do_write(5, 32'h0);
    read_ch(5, d);
    chk("R7 zero write stops", d, 32'h8);
  endtask

  task automatic t_fetch_and_stop();
    logic [31:0] d;
    do_write(2, 32'h8000_0000);
    chk("R7 fetch pulse", 32'(fetch_go), 32'h4);
    read_ch(2, d);
    chk("R7 run clears stop", d, 32'h8000_0000);
    @(negedge clk);
    chk("R7 fetch pulse one cycle", 32'(fetch_go), 32'h0);
    do_write(2, 32'h0040_0000);
    read_ch(2, d);
    chk("R7 mask-run keeps stop clear", d, 32'h0);
    chk("R11 run dropped", 32'(run_o[2]), 32'h0);
    do_write(2, 32'h0);
    read_ch(2, d);
    chk("R7 stop forced", d, 32'h8);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    @(negedge clk); ev_start[3] = 1'b1;
    idle();
    read_ch(3, d);
    chk("R4 start flag", d, 32'hA);
    chk("R9 start ungated", 32'(irq_sum), 32'h8);
    do_write(3, 32'h2);
    read_ch(3, d);
    chk("R3 start cleared", d, 32'h8);
    chk("R10 irq low after clear", 32'(irq_o), 32'h0);
    // clearing write with end event in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CHW'(3); wr_data = 32'h4; ev_end[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_end = '0;
    read_ch(3, d);
    chk("R3 event beats clear", d, 32'hC);
    chk("R9 end ungated", 32'(irq_sum), 32'h8);
    do_write(3, 32'h4);
    read_ch(3, d);
    chk("R3 end cleared", d, 32'h8);
    @(negedge clk); ev_buserr[3] = 1'b1;
    idle();
    read_ch(3, d);
    chk("R4 bus error flag", d, 32'h9);
    chk("R9 bus error silent", 32'(irq_o), 32'h0);
    do_write(3, 32'h1);
    read_ch(3, d);
    chk("R3 bus error cleared", d, 32'h8);
  endtask

  task automatic t_eor_gate();
    logic [31:0] d;
    @(negedge clk); ev_eor[7] = 1'b1;
    idle();
    read_ch(7, d);
    chk("R4 eor flag", d, 32'h208);
    chk("R9 eor gated out", 32'(irq_sum), 32'h0);
    do_write(7, 32'h1040_0000);
    read_ch(7, d);
    chk("R2 eor enable stored", d, 32'h1000_0208);
    chk("R9 eor gated in", 32'(irq_sum), 32'h80);
    do_write(7, 32'h1040_0200);
    read_ch(7, d);
    chk("R3 eor cleared", d, 32'h1000_0008);
    chk("R10 irq low", 32'(irq_o), 32'h0);
    do_write(7, 32'h0);
  endtask

  task automatic t_stop_event();
    logic [31:0] d;
    do_write(9, 32'hA000_0000);
    read_ch(9, d);
    chk("R7 run with stop enable", d, 32'hA000_0000);
    chk("R9 no stop yet", 32'(irq_sum), 32'h0);
    @(negedge clk); ev_stop[9] = 1'b1;
    idle();
    read_ch(9, d);
    chk("R4 stop flag", d, 32'hA000_0008);
    chk("R9 stop summary", 32'(irq_sum), 32'h200);
    do_write(9, 32'h0);
    chk("R9 stop enable off", 32'(irq_sum), 32'h0);
  endtask

  task automatic t_ras();
    logic [31:0] d;
    do_write(11, 32'h0080_0000);
    read_ch(11, d);
    chk("R2 ras enable stored", d, 32'h0080_0008);
    @(negedge clk); req_active[11] = 1'b1;
    read_ch(11, d);
    chk("R6 request bit live", d, 32'h0080_0108);
    @(negedge clk); ev_ras[11] = 1'b1;
    idle();
    read_ch(11, d);
    chk("R5 ras flag set", d, 32'h0080_0118);
    chk("R9 ras gated in", 32'(irq_sum), 32'h800);
    @(negedge clk);
    read_ch(11, d);
    chk("R5 ras held with request", d, 32'h0080_0118);
    req_active[11] = 1'b0;
    @(negedge clk);
    read_ch(11, d);
    chk("R5 ras cleared with request", d, 32'h0080_0008);
    chk("R10 irq low", 32'(irq_o), 32'h0);
    do_write(11, 32'h0);
  endtask

  task automatic t_cmp();
    logic [31:0] d;
    do_write(4, 32'h0200_0000);
    read_ch(4, d);
    chk("R8 compare set", d, 32'h408);
    chk("R11 cmp_o", 32'(cmp_o), 32'h10);
    do_write(4, 32'h0100_0000);
    read_ch(4, d);
    chk("R8 compare cleared", d, 32'h8);
    do_write(4, 32'h0300_0000);
    read_ch(4, d);
    chk("R8 set wins over clear", d, 32'h408);
    do_write(4, 32'h0100_0000);
  endtask

  task automatic t_multi_irq();
    @(negedge clk); ev_start[0] = 1'b1; ev_end[15] = 1'b1;
    idle();
    chk("R9 two channels", 32'(irq_sum), 32'h8001);
    chk("R10 irq high", 32'(irq_o), 32'h1);
    do_write(0, 32'h2);
    chk("R10 one left", 32'(irq_o), 32'h1);
    do_write(15, 32'h4);
    chk("R10 all clear", 32'(irq_o), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; rd_ch = '0;
    ev_buserr = '0; ev_start = '0; ev_end = '0;
    ev_stop = '0; ev_eor = '0; ev_ras = '0; req_active = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control_store();
    t_fetch_and_stop();
    t_w1c();
    t_eor_gate();
    t_stop_event();
    t_ras();
    t_cmp();
    t_multi_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule